// File: doc/BRIEF.md
# Preset Table Stepper

This block keeps a table of filter presets and hands one of them to the filter control logic at a time. Each preset packs a 2-bit band code and three 8-bit capacitor codes for centre frequency, bandwidth and match. In direct mode the block passes on a single setting that software writes. When the fast-step pin is high, the block steps an index through the table instead. Each rising edge on a chip-select line applies the preset at the current index and moves the index one place.

The walk covers a window set by a start index and a stop index. A direction bit picks whether the index counts up or down. When the index reaches the stop value, the next step reloads the start value, so the walk repeats. The window may also cross the top or bottom of the table. The current index is visible on an output, so software can see which preset the next edge will apply. The table is filled through a simple write port.

Top module: `preset_stepper`

## Requirements
- R1: After synchronous active-low reset, next_ptr is 0, active_set is 0, and the start, stop and direction registers are 0.
- R2: While fl_mode is low, active_set equals the last value written with direct_we, one clock after the write. A setting is packed as band [25:24], centre code [23:16], bandwidth code [15:8] and match code [7:0]. Band 0 is bypass and bands 1 to 3 select a filter.
- R3: The first clock with fl_mode high loads next_ptr with the start index. active_set keeps its direct-mode value until the first chip-select rising edge.
- R4: In fast-step mode, each rising edge of cs_line applies the table entry at next_ptr to active_set. With the direction bit at 0 it also increments next_ptr. Both results are visible within three clocks of the raw edge.
- R5: With the direction bit at 1, each such edge decrements next_ptr.
- R6: When next_ptr equals the stop index, the next edge applies that entry and reloads next_ptr with the start index, in either direction.
- R7: Rising edges of cs_line while fl_mode is low leave next_ptr unchanged, and active_set keeps showing the direct setting.
- R8: In fast-step mode, a falling edge of cs_line, or no edge at all, leaves next_ptr and active_set unchanged.
- R9: A table write with tbl_we stores tbl_data at tbl_idx. A later walk that reaches that index applies the stored value.
- R10: Index arithmetic wraps around the table: counting up from 127 gives 0, and counting down from 0 gives 127. This lets a window pass through the table boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fl_mode | input | 1 | Fast-step mode select, synchronous to clk |
| cs_line | input | 1 | Asynchronous chip-select line whose rising edges step the walk |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | 7 | Table write index |
| tbl_data | input | 26 | Table write data (packed setting) |
| bnd_we | input | 1 | Writes start, stop and direction together |
| bnd_start | input | 7 | Start index |
| bnd_stop | input | 7 | Stop index |
| bnd_down | input | 1 | Direction: 0 up, 1 down |
| direct_we | input | 1 | Direct setting write strobe |
| direct_data | input | 26 | Direct setting value |
| next_ptr | output | 7 | Index the next edge will apply |
| active_set | output | 26 | Setting currently driven to the filter |

## Verification
The hardest case to reach is a walk whose window crosses the table boundary. Reaching it needs a start index near the top of the table, a stop index near the bottom, and enough synchronized edges to pass 127 in both directions. The bench sets the window to start 126 and stop 1 counting up. It then pulses the chip-select line through the full cycle, and checks the applied entry and the index after each edge. A down walk that reloads at its stop value and edges sent while fast-step mode is low complete the ordering cases.

// File: rtl/preset_pkg.sv
package preset_pkg;
    localparam int BAND_W = 2;
    localparam int CODE_W = 8;
    localparam int SET_W  = BAND_W + 3 * CODE_W;

    typedef struct packed {
        logic [BAND_W-1:0] band;
        logic [CODE_W-1:0] fc;
        logic [CODE_W-1:0] bw;
        logic [CODE_W-1:0] match;
    } setting_t;
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    // STAGES synchronizer flops followed by one history flop
    logic [STAGES:0] sh_q;
    logic [STAGES:0] sh_d;

    assign sh_d[0] = din;
    for (genvar g = 1; g <= STAGES; g++) begin : g_chain
        assign sh_d[g] = sh_q[g-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/preset_table.sv
module preset_table #(
    parameter int DEPTH = 128,
    parameter int WID   = 26,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [WID-1:0]   wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [WID-1:0]   rdata
);
    logic [WID-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[widx] <= wdata;
    end

    assign rdata = mem[ridx];
endmodule

// File: rtl/ptr_step.sv
module ptr_step #(
    parameter int DEPTH = 128,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [IDX_W-1:0] cur,
    input  logic [IDX_W-1:0] start,
    input  logic [IDX_W-1:0] stop,
    input  logic             down,
    output logic [IDX_W-1:0] nxt
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    always_comb begin
        if (cur == stop)       nxt = start;
        else if (!down)        nxt = (cur == LAST) ? '0 : cur + 1'b1;
        else                   nxt = (cur == '0) ? LAST : cur - 1'b1;
    end
endmodule

// File: rtl/preset_stepper.sv
module preset_stepper
    import preset_pkg::*;
#(
    parameter int DEPTH     = 128,
    parameter int SYNC_STGS = 2,
    localparam int IDX_W    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fl_mode,
    input  logic             cs_line,
    input  logic             tbl_we,
    input  logic [IDX_W-1:0] tbl_idx,
    input  logic [SET_W-1:0] tbl_data,
    input  logic             bnd_we,
    input  logic [IDX_W-1:0] bnd_start,
    input  logic [IDX_W-1:0] bnd_stop,
    input  logic             bnd_down,
    input  logic             direct_we,
    input  logic [SET_W-1:0] direct_data,
    output logic [IDX_W-1:0] next_ptr,
    output logic [SET_W-1:0] active_set
);
    typedef struct packed {
        logic [IDX_W-1:0] ptr;
        logic [IDX_W-1:0] start;
        logic [IDX_W-1:0] stop;
        logic             down;
        logic             mode;
        setting_t         direct;
        setting_t         applied;
    } state_t;

    state_t st_q, st_d;

    logic             cs_rise;
    logic [SET_W-1:0] tbl_rd;
    logic [IDX_W-1:0] step_nxt;
    logic [IDX_W-1:0] start_idx;
    logic             mode_seen;

    edge_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (cs_line),
        .rise (cs_rise)
    );

    preset_table #(.DEPTH(DEPTH), .WID(SET_W)) u_tbl (
        .clk  (clk),
        .we   (tbl_we),
        .widx (tbl_idx),
        .wdata(tbl_data),
        .ridx (st_q.ptr),
        .rdata(tbl_rd)
    );

    ptr_step #(.DEPTH(DEPTH)) u_step (
        .cur  (st_q.ptr),
        .start(st_q.start),
        .stop (st_q.stop),
        .down (st_q.down),
        .nxt  (step_nxt)
    );

    always_comb begin
        st_d = st_q;
        st_d.mode = fl_mode;
        if (bnd_we) begin
            st_d.start = bnd_start;
            st_d.stop  = bnd_stop;
            st_d.down  = bnd_down;
        end
        if (direct_we) st_d.direct = setting_t'(direct_data);

        if (!fl_mode) begin
            // direct mode: follow the written setting, table walk frozen
            st_d.applied = direct_we ? setting_t'(direct_data) : st_q.direct;
        end else if (!st_q.mode) begin
            // first cycle of fast-step: arm pointer, hold output
            st_d.ptr = st_q.start;
        end else if (cs_rise) begin
            st_d.applied = setting_t'(tbl_rd);
            st_d.ptr     = step_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign next_ptr   = st_q.ptr;
    assign active_set = st_q.applied;
    assign start_idx  = st_q.start;
    assign mode_seen  = st_q.mode;
endmodule

// File: rtl/preset_stepper_chk.sv
module preset_stepper_chk #(
    parameter int IDX_W = 7,
    parameter int SET_W = 26
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fl_mode,
    input logic             mode_seen,
    input logic             cs_rise,
    input logic [IDX_W-1:0] start_idx,
    input logic [IDX_W-1:0] next_ptr,
    input logic [SET_W-1:0] active_set
);
    // R7: pointer frozen while fast-step mode is off
    assert_ptr_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_mode && rst_n) |=> $stable(next_ptr));

    // R3: entering fast-step mode arms the start index
    assert_entry_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_mode && !mode_seen) |=> (next_ptr == $past(start_idx)));

    // R8: no synchronized edge in fast-step mode keeps the output
    assert_hold_output_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_mode && !cs_rise) |=> $stable(active_set));

    // R6: a step either moves one place or reloads the start index
    assert_step_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_mode && mode_seen && cs_rise) |=>
            ((next_ptr == $past(start_idx)) ||
             (next_ptr == $past(next_ptr) + 1'b1) ||
             (next_ptr == $past(next_ptr) - 1'b1)));

    // R1: outputs are never unknown out of reset
    assert_known_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(next_ptr));
endmodule

bind preset_stepper preset_stepper_chk #(.IDX_W(IDX_W), .SET_W(preset_pkg::SET_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fl_mode   (fl_mode),
    .mode_seen (mode_seen),
    .cs_rise   (cs_rise),
    .start_idx (start_idx),
    .next_ptr  (next_ptr),
    .active_set(active_set)
);

// File: tb/preset_stepper_test.sv
module preset_stepper_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        fl_mode = 0;
    logic        cs_line = 0;
    logic        tbl_we = 0;
    logic [6:0]  tbl_idx = '0;
    logic [25:0] tbl_data = '0;
    logic        bnd_we = 0;
    logic [6:0]  bnd_start = '0;
    logic [6:0]  bnd_stop = '0;
    logic        bnd_down = 0;
    logic        direct_we = 0;
    logic [25:0] direct_data = '0;
    logic [6:0]  next_ptr;
    logic [25:0] active_set;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    preset_stepper uut (
        .clk(clk), .rst_n(rst_n), .fl_mode(fl_mode), .cs_line(cs_line),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_data(tbl_data),
        .bnd_we(bnd_we), .bnd_start(bnd_start), .bnd_stop(bnd_stop),
        .bnd_down(bnd_down), .direct_we(direct_we), .direct_data(direct_data),
        .next_ptr(next_ptr), .active_set(active_set)
    );

    // packing per R2: band, centre, bandwidth, match
    function automatic logic [25:0] pat(input int i);
        logic [7:0] b;
        b = 8'(i);
        return {b[1:0], b, ~b, b ^ 8'h5A};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic set_bounds(input int s, input int e, input logic dn);
        @(negedge clk);
        bnd_we = 1; bnd_start = 7'(s); bnd_stop = 7'(e); bnd_down = dn;
        @(negedge clk);
        bnd_we = 0;
    endtask

    task automatic set_direct(input logic [25:0] v);
        @(negedge clk);
        direct_we = 1; direct_data = v;
        @(negedge clk);
        direct_we = 0;
    endtask

    task automatic pulse_cs;
        @(negedge clk); cs_line = 1;
        idle(5);
        cs_line = 0;
        idle(5);
    endtask

    task automatic enter_mode;
        @(negedge clk); fl_mode = 1;
        idle(2);
    endtask

    task automatic leave_mode;
        @(negedge clk); fl_mode = 0;
        idle(2);
    endtask

    task automatic t_reset;
        chk("R1 next_ptr", 32'(next_ptr), 0);
        chk("R1 active_set", 32'(active_set), 0);
        // bounds are zero: entering mode arms index 0
        enter_mode();
        chk("R1 start zero", 32'(next_ptr), 0);
        leave_mode();
    endtask

    task automatic t_direct;
        set_direct(26'h2AB_CDEF);
        chk("R2 direct value", 32'(active_set), 32'h2AB_CDEF);
        set_direct({2'd0, 8'h11, 8'h22, 8'h33});
        chk("R2 bypass value", 32'(active_set), {6'd0, 2'd0, 8'h11, 8'h22, 8'h33});
    endtask

    task automatic t_fill;
        for (int i = 0; i < 128; i++) begin
            @(negedge clk);
            tbl_we = 1; tbl_idx = 7'(i); tbl_data = pat(i);
        end
        @(negedge clk); tbl_we = 0;
    endtask

    task automatic t_walk_up;
        set_direct(26'h1F0_0F0F);
        set_bounds(3, 6, 0);
        enter_mode();
        chk("R3 armed start", 32'(next_ptr), 3);
        chk("R3 output held", 32'(active_set), 32'h1F0_0F0F);
        for (int i = 3; i <= 6; i++) begin
            pulse_cs();
            chk("R4 applied entry", 32'(active_set), 32'(pat(i)));
            chk(i == 6 ? "R6 reload up" : "R4 increment", 32'(next_ptr), i == 6 ? 3 : i + 1);
        end
        // R8: no edge, falling edge only
        idle(6);
        chk("R8 hold ptr", 32'(next_ptr), 3);
        chk("R8 hold out", 32'(active_set), 32'(pat(6)));
        leave_mode();
    endtask

    task automatic t_walk_down;
        set_bounds(10, 8, 1);
        enter_mode();
        chk("R5 armed", 32'(next_ptr), 10);
        pulse_cs();
        chk("R5 entry 10", 32'(active_set), 32'(pat(10)));
        chk("R5 decrement", 32'(next_ptr), 9);
        pulse_cs();
        chk("R5 entry 9", 32'(active_set), 32'(pat(9)));
        chk("R5 decrement 2", 32'(next_ptr), 8);
        pulse_cs();
        chk("R6 entry 8", 32'(active_set), 32'(pat(8)));
        chk("R6 reload down", 32'(next_ptr), 10);
        leave_mode();
    endtask

    task automatic t_ignored;
        set_direct(26'h0AA_5555);
        // pointer left at 10 by the down walk
        pulse_cs();
        pulse_cs();
        chk("R7 ptr kept", 32'(next_ptr), 10);
        chk("R7 direct shown", 32'(active_set), 32'h0AA_5555);
    endtask

    task automatic t_boundary;
        set_bounds(126, 1, 0);
        enter_mode();
        chk("R10 armed", 32'(next_ptr), 126);
        pulse_cs();
        chk("R10 step to 127", 32'(next_ptr), 127);
        pulse_cs();
        chk("R10 wrap to 0", 32'(next_ptr), 0);
        chk("R10 entry 127", 32'(active_set), 32'(pat(127)));
        pulse_cs();
        chk("R10 entry 0", 32'(active_set), 32'(pat(0)));
        pulse_cs();
        chk("R6 reload 126", 32'(next_ptr), 126);
        leave_mode();
        set_bounds(1, 126, 1);
        enter_mode();
        pulse_cs();
        chk("R10 down to 0", 32'(next_ptr), 0);
        pulse_cs();
        chk("R10 down wrap", 32'(next_ptr), 127);
        leave_mode();
    endtask

    task automatic t_rewrite;
        @(negedge clk);
        tbl_we = 1; tbl_idx = 7'd50; tbl_data = 26'h3C3_C3C3;
        @(negedge clk); tbl_we = 0;
        set_bounds(50, 51, 0);
        enter_mode();
        pulse_cs();
        chk("R9 rewritten entry", 32'(active_set), 32'h3C3_C3C3);
        pulse_cs();
        chk("R9 neighbour intact", 32'(active_set), 32'(pat(51)));
        leave_mode();
    endtask

    initial begin
        idle(3);
        rst_n = 1;
        idle(1);
        t_reset();
        t_direct();
        t_fill();
        t_walk_up();
        t_walk_down();
        t_ignored();
        t_boundary();
        t_rewrite();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule